// File: doc/BRIEF.md
# Single-Cycle Core with Conditional Memory-Indirect Jump

This block is a 32-bit single-cycle processor core. It runs a small instruction set: register-to-register arithmetic and logic operations, plus one three-register "jump-and-set" operation. The jump-and-set operation subtracts its second source register from its first. When the difference is not zero, the core writes the difference to the destination register and loads the next program counter from the data-memory word at that difference. When the difference is zero, the core falls through to the next instruction and writes the return address (PC+4) into register 31.

Every rising clock edge retires exactly one instruction. The core holds its instruction and data storage as internal word arrays. A host fills these arrays through two simple word-indexed write ports, normally while reset is held. The core itself only reads the data array. A combinational peek port shows any register, and the current program counter is always visible. Together these let the surrounding logic watch the architectural state after every instruction.

Top module: `cjs_core`

## Requirements
- R1: While reset (`rstN` low) is asserted, the program counter reads 0 and every register reads 0.
- R2: Opcode field bits [31:26] = 000000 with shift field [10:6] = 0 is a register operation on rs [25:21] and rt [20:16], written to rd [15:11]. The funct field [5:0] selects the operation: 100000 add, 100010 subtract (rs-rt), 100100 AND, 100101 OR, 101010 signed set-less-than (result 1 or 0). The program counter then advances by 4.
- R3: A register operation writes rd even when its result is zero.
- R4: Opcode 100000 is jump-and-set. When rs-rt is nonzero, rd receives rs-rt and the next program counter is the data word at byte address rs-rt.
- R5: For jump-and-set with rs equal to rt, rd is left unchanged, register 31 receives PC+4, and the program counter advances by 4.
- R6: Register 0 always reads 0, and writes aimed at it have no effect.
- R7: Program counter and data addresses are byte addresses. Bits [1:0] are ignored when a word is selected, so a jump-and-set difference of 15 reads the data word at index 3.
- R8: Any other opcode, any unlisted funct code, or a nonzero shift field in a register operation writes no register and advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction retires per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| imemWrEn | input | 1 | Write strobe for the instruction array |
| imemWrAddr | input | 6 | Word index for an instruction-array write |
| imemWrData | input | 32 | Instruction word to store |
| dmemWrEn | input | 1 | Write strobe for the data array |
| dmemWrAddr | input | 6 | Word index for a data-array write |
| dmemWrData | input | 32 | Data word to store |
| peekAddr | input | 5 | Register index to observe |
| peekData | output | 32 | Current contents of the observed register |
| pcOut | output | 32 | Current program counter (byte address) |

## Verification
The hardest state to reach from the ports is any nonzero register value, because no instruction loads a constant. Every register starts at zero after reset, so the stimulus first runs a jump-and-set with equal zero sources. This deposits a return address in register 31. Register operations then double and combine that value into the operands 20, 8 and 16. Only once those operands exist can the program drive the nonzero-difference jumps. These include one whose difference has nonzero low bits, and one whose destination is register 0. The jumps also return to an earlier address, so the equal-operand fall-through case is exercised twice.

// File: rtl/cjs_pkg.sv
package cjs_pkg;

  localparam int XLEN     = 32;
  localparam int REG_CNT  = 32;
  localparam int REG_AW   = $clog2(REG_CNT);
  localparam logic [REG_AW-1:0] LINK_REG = REG_AW'(REG_CNT - 1);

  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] OPC_JSET = 6'b100000;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } aluOpE;

  typedef struct packed {
    logic regWrite;
    logic wbSelAlu;
    logic dstSelRd;
    logic pcSelMem;
  } ctrlS;

endpackage

// File: rtl/cjs_control.sv
module cjs_control
  import cjs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  input  logic       aluZero,
  output aluOpE      aluOp,
  output ctrlS       ctrl
);

  logic isReg;
  logic isJset;
  logic knownFunct;
  aluOpE fnOp;

  assign isReg  = (opcode == OPC_REG);
  assign isJset = (opcode == OPC_JSET);

  always_comb begin
    knownFunct = 1'b1;
    fnOp       = ALU_ADD;
    unique case (funct)
      FN_ADD:  fnOp = ALU_ADD;
      FN_SUB:  fnOp = ALU_SUB;
      FN_AND:  fnOp = ALU_AND;
      FN_OR:   fnOp = ALU_OR;
      FN_SLT:  fnOp = ALU_SLT;
      default: knownFunct = 1'b0;
    endcase
  end

  // jump-and-set always subtracts, whatever its funct bits hold
  assign aluOp = isJset ? ALU_SUB : fnOp;

  // unused selects are driven low
  always_comb begin
    ctrl.regWrite = isJset | (isReg & knownFunct & (shamt == 5'd0));
    ctrl.wbSelAlu = isReg | (isJset & ~aluZero);
    ctrl.dstSelRd = isReg | (isJset & ~aluZero);
    ctrl.pcSelMem = isJset & opcode[5] & ~aluZero;
  end

  // a memory-indirect jump always writes the difference into rd
  p_jump_writes_rd_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pcSelMem |-> (ctrl.regWrite && ctrl.wbSelAlu && ctrl.dstSelRd));

  // unsupported opcodes never write
  p_illegal_nowrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!isReg && !isJset) |-> (!ctrl.regWrite && !ctrl.pcSelMem));

endmodule

// File: rtl/cjs_datapath.sv
module cjs_datapath
  import cjs_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IMEM_AW = $clog2(IMEM_WORDS),
  localparam int DMEM_AW = $clog2(DMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               imemWrEn,
  input  logic [IMEM_AW-1:0] imemWrAddr,
  input  logic [XLEN-1:0]    imemWrData,
  input  logic               dmemWrEn,
  input  logic [DMEM_AW-1:0] dmemWrAddr,
  input  logic [XLEN-1:0]    dmemWrData,
  input  logic [REG_AW-1:0]  peekAddr,
  output logic [XLEN-1:0]    peekData,
  output logic [XLEN-1:0]    pcOut,
  input  aluOpE              aluOp,
  input  ctrlS               ctrl,
  output logic [5:0]         opcode,
  output logic [4:0]         shamt,
  output logic [5:0]         funct,
  output logic               aluZero
);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] regs [REG_CNT];

  logic [XLEN-1:0]   pcQ;
  logic [XLEN-1:0]   pcPlus4;
  logic [XLEN-1:0]   nextPc;
  logic [XLEN-1:0]   instr;
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, wbDst;
  logic [XLEN-1:0]   rsVal, rtVal;
  logic [XLEN-1:0]   aluResult;
  logic [XLEN-1:0]   memWord;
  logic [XLEN-1:0]   wbData;

  always_ff @(posedge clk) begin
    if (imemWrEn) imem[imemWrAddr] <= imemWrData;
  end

  always_ff @(posedge clk) begin
    if (dmemWrEn) dmem[dmemWrAddr] <= dmemWrData;
  end

  // fetch: byte PC, low two bits dropped
  assign instr  = imem[pcQ[IMEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];

  assign rsVal = (rsIdx == '0) ? '0 : regs[rsIdx];
  assign rtVal = (rtIdx == '0) ? '0 : regs[rtIdx];

  always_comb begin
    unique case (aluOp)
      ALU_ADD: aluResult = rsVal + rtVal;
      ALU_SUB: aluResult = rsVal - rtVal;
      ALU_AND: aluResult = rsVal & rtVal;
      ALU_OR:  aluResult = rsVal | rtVal;
      ALU_SLT: aluResult = ($signed(rsVal) < $signed(rtVal)) ? XLEN'(1) : '0;
      default: aluResult = '0;
    endcase
  end

  assign aluZero = (aluResult == '0);
  assign memWord = dmem[aluResult[DMEM_AW+1:2]];

  assign pcPlus4 = pcQ + XLEN'(4);
  assign nextPc  = ctrl.pcSelMem ? memWord : pcPlus4;
  assign wbData  = ctrl.wbSelAlu ? aluResult : pcPlus4;
  assign wbDst   = ctrl.dstSelRd ? rdIdx : LINK_REG;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= nextPc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
    end else if (ctrl.regWrite && (wbDst != '0)) begin
      regs[wbDst] <= wbData;
    end
  end

  assign peekData = regs[peekAddr];
  assign pcOut    = pcQ;

  p_reg_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OPC_REG) |=> (pcQ == $past(pcQ) + XLEN'(4)));

  p_jump_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OPC_JSET && !aluZero) |=> (pcQ == $past(memWord)));

  p_link_fallthru_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OPC_JSET && aluZero) |=>
      (pcQ == $past(pcQ) + XLEN'(4) && regs[LINK_REG] == $past(pcQ) + XLEN'(4)));

  p_zero_reg_r6: assert property (@(posedge clk) disable iff (!rstN)
    regs[0] == '0);

endmodule

// File: rtl/cjs_core.sv
module cjs_core
  import cjs_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IMEM_AW = $clog2(IMEM_WORDS),
  localparam int DMEM_AW = $clog2(DMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               imemWrEn,
  input  logic [IMEM_AW-1:0] imemWrAddr,
  input  logic [31:0]        imemWrData,
  input  logic               dmemWrEn,
  input  logic [DMEM_AW-1:0] dmemWrAddr,
  input  logic [31:0]        dmemWrData,
  input  logic [4:0]         peekAddr,
  output logic [31:0]        peekData,
  output logic [31:0]        pcOut
);

  aluOpE      aluOp;
  ctrlS       ctrl;
  logic [5:0] opcode;
  logic [4:0] shamt;
  logic [5:0] funct;
  logic       aluZero;

  cjs_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opcode  (opcode),
    .shamt   (shamt),
    .funct   (funct),
    .aluZero (aluZero),
    .aluOp   (aluOp),
    .ctrl    (ctrl)
  );

  cjs_datapath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .imemWrEn   (imemWrEn),
    .imemWrAddr (imemWrAddr),
    .imemWrData (imemWrData),
    .dmemWrEn   (dmemWrEn),
    .dmemWrAddr (dmemWrAddr),
    .dmemWrData (dmemWrData),
    .peekAddr   (peekAddr),
    .peekData   (peekData),
    .pcOut      (pcOut),
    .aluOp      (aluOp),
    .ctrl       (ctrl),
    .opcode     (opcode),
    .shamt      (shamt),
    .funct      (funct),
    .aluZero    (aluZero)
  );

endmodule

// File: tb/cjs_core_tb.sv
module cjs_core_tb;

  localparam int WORDS = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        imemWrEn = 1'b0;
  logic [5:0]  imemWrAddr = '0;
  logic [31:0] imemWrData = '0;
  logic        dmemWrEn = 1'b0;
  logic [5:0]  dmemWrAddr = '0;
  logic [31:0] dmemWrData = '0;
  logic [4:0]  peekAddr = '0;
  logic [31:0] peekData;
  logic [31:0] pcOut;

  always #10 clk = ~clk;  // 50 MHz

  cjs_core u_dut (
    .clk(clk), .rstN(rstN),
    .imemWrEn(imemWrEn), .imemWrAddr(imemWrAddr), .imemWrData(imemWrData),
    .dmemWrEn(dmemWrEn), .dmemWrAddr(dmemWrAddr), .dmemWrData(dmemWrData),
    .peekAddr(peekAddr), .peekData(peekData), .pcOut(pcOut)
  );

  typedef struct {
    bit          isPc;
    logic [4:0]  idx;
    logic [31:0] val;
    string       tag;
  } expS;

  expS expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [31:0] mImem [WORDS];
  logic [31:0] mDmem [WORDS];
  logic [31:0] mReg  [32];
  logic [31:0] mPc;

  function automatic logic [31:0] rop(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] jset(int rs, int rt, int rd);
    return {6'b100000, 5'(rs), 5'(rt), 5'(rd), 11'd0};
  endfunction

  task automatic compare(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // monitor: drains expected items at the negedge after each retire
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expS it;
        it = expQ.pop_front();
        if (it.isPc) compare(it.tag, "pc", pcOut, it.val);
        else begin
          peekAddr = it.idx;
          #1;
          compare(it.tag, $sformatf("r%0d", it.idx), peekData, it.val);
        end
      end
    end
  end

  // driver: model one instruction from the requirements, then push results
  task automatic stepOne();
    logic [31:0] ins, a, b, d, val, nxt;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, dst, sh;
    bit          wr;
    string       tag;
    ins = mImem[mPc[7:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16];
    rd = ins[15:11]; sh = ins[10:6]; fn = ins[5:0];
    a = mReg[rs]; b = mReg[rt];
    nxt = mPc + 32'd4; wr = 1'b0; dst = rd; val = '0; tag = "R8";
    if (op == 6'b000000) begin
      wr = (sh == 5'd0);
      case (fn)
        6'b100000: val = a + b;
        6'b100010: val = a - b;
        6'b100100: val = a & b;
        6'b100101: val = a | b;
        6'b101010: val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        default:   wr = 1'b0;
      endcase
      if (wr) tag = (val == 0) ? "R3" : "R2";
    end else if (op == 6'b100000) begin
      d = a - b;
      wr = 1'b1;
      if (d != 0) begin
        val = d; nxt = mDmem[d[7:2]];
        tag = (d[1:0] != 2'b00) ? "R7" : "R4";
      end else begin
        dst = 5'd31; val = mPc + 32'd4; tag = "R5";
      end
    end
    if (wr && dst == 5'd0) tag = "R6";
    if (wr && dst != 5'd0) mReg[dst] = val;
    mPc = nxt;
    @(posedge clk);
    #1;
    expQ.push_back('{1'b1, 5'd0, nxt, tag});
    expQ.push_back('{1'b0, (wr ? dst : rd), mReg[wr ? dst : rd], tag});
    if (tag == "R5") expQ.push_back('{1'b0, rd, mReg[rd], "R5"});
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin mImem[i] = '0; mDmem[i] = '0; end
    for (int i = 0; i < 32; i++) mReg[i] = '0;
    mPc = '0;
    mImem[0]  = jset(0, 0, 5);
    mImem[1]  = rop(31, 0, 1, 0, 6'b100000);
    mImem[2]  = rop(1, 1, 2, 0, 6'b100000);
    mImem[3]  = rop(2, 2, 3, 0, 6'b100000);
    mImem[4]  = rop(3, 1, 4, 0, 6'b100000);
    mImem[5]  = jset(4, 2, 5);               // 20-8=12 -> dmem word 3
    mImem[16] = jset(4, 4, 6);               // equal -> link
    mImem[17] = rop(2, 4, 7, 0, 6'b100010);  // 8-20
    mImem[18] = rop(7, 0, 8, 0, 6'b101010);  // slt -> 1
    mImem[19] = rop(0, 7, 9, 0, 6'b101010);  // slt -> 0
    mImem[20] = rop(4, 3, 10, 0, 6'b100100);
    mImem[21] = rop(4, 2, 11, 0, 6'b100101);
    mImem[22] = rop(4, 4, 0, 0, 6'b100000);  // write r0
    mImem[23] = {6'b000010, 26'h0421800};    // unknown opcode
    mImem[24] = rop(4, 4, 14, 0, 6'b000000); // unknown funct
    mImem[25] = rop(4, 4, 14, 3, 6'b100000); // nonzero shift field
    mImem[26] = rop(4, 4, 1, 0, 6'b100010);  // zero result
    mImem[27] = jset(4, 1, 0);               // 20 -> word 5, rd=r0
    mImem[32] = jset(3, 8, 13);              // 15 -> word 3
    mDmem[3] = 32'd64;
    mDmem[5] = 32'd128;

    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      imemWrEn = 1'b1; imemWrAddr = 6'(i); imemWrData = mImem[i];
      dmemWrEn = 1'b1; dmemWrAddr = 6'(i); dmemWrData = mDmem[i];
    end
    @(negedge clk);
    imemWrEn = 1'b0; dmemWrEn = 1'b0;
    #2;
    compare("R1", "pc in reset", pcOut, 32'd0);
    peekAddr = 5'd31; #1;
    compare("R1", "r31 in reset", peekData, 32'd0);
    peekAddr = 5'd5; #1;
    compare("R1", "r5 in reset", peekData, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int s = 0; s < 20; s++) stepOne();
    @(negedge clk);
    #10;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule